// File: doc/BRIEF.md
# Opcode-Tracking Lane Striper for Dual Serial Flash

This block sits between a byte-wide transmit queue, a byte-wide receive queue and a set of parallel serial byte lanes (one or two lanes, set by a parameter). While a chip select is active it watches the first byte exchanged and reads it as a serial-flash command code. From that code it knows how many address and dummy bytes follow. Once those bytes have been exchanged it switches into a striped mode. In that mode each lane drives its own flash device, so a group of bytes is spread bit by bit across the lanes.

Before striping begins, every transfer takes one byte from the transmit queue and copies it onto all lanes. Only the byte that comes back on lane 0 goes into the receive queue. In striped mode a transfer takes one byte per lane and applies a bit transpose before sending. The bytes that come back from the lanes go through the inverse transpose and are all written to the receive queue. Transfers are requested by the surrounding controller through `xfer_req`. Each launch is a one-cycle `lane_go` pulse, and the lane serializer finishes it with a one-cycle `lane_ack`. Only one transfer is in flight at a time.

Top module: `cmd_snoop_striper`

## Requirements
- R1: After reset, and during any cycle in which `cs_active` is low, no transfer is launched (`lane_go` and `tx_pop` stay 0), and the command tracker is put back into its watching state.
- R2: In the watching state, the byte sent by the next completed transfer is decoded as a command. Codes 0x02, 0x03, 0x32 and 0xA2 are followed by 3 further broadcast transfers before striping starts. Codes 0x0B, 0x3B, 0x6B and 0xBB are followed by 4. Code 0xEB is followed by 6.
- R3: Any other command code keeps every later transfer in broadcast form until `cs_active` is released.
- R4: In broadcast form a launch pops one byte (`tx_pop_cnt` = 1) and drives that byte, taken from `tx_head[7:0]`, on every lane. On completion one byte is pushed (`rx_push_cnt` = 1): `rx_data[7:0]` is `lane_rx[7:0]` and the upper bytes are 0.
- R5: In striped form a launch pops LANES bytes, with head byte k at `tx_head[8k+7:8k]`. Output lane byte j, bit b carries input bit number b·LANES + j, where input bits are numbered upward from byte 0 bit 0.
- R6: In striped form a completion pushes LANES bytes. Bit number b·LANES + j of `rx_data` equals bit b of lane byte j of `lane_rx`.
- R7: A completion that arrives while `rx_full` is 1 pushes nothing and raises `ev_rx_overflow` for that cycle.
- R8: A request with an active chip select, no transfer in flight and an empty transmit queue launches nothing. It raises `ev_tx_underflow` for that cycle, unless `linear_mode` is 1.
- R9: In striped form, a request made while the queue holds more than zero but fewer than LANES bytes waits. It pops nothing and raises no underflow.
- R10: While a transfer is in flight, no new launch occurs until its `lane_ack` is seen. A `lane_ack` with no transfer in flight is ignored.
- R11: Releasing `cs_active` ends striped or plain-broadcast operation. After the next activation, the first completed transfer is decoded as a command again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_active | input | 1 | Some chip select is asserted |
| linear_mode | input | 1 | Memory-mapped read mode; suppresses underflow events |
| xfer_req | input | 1 | Controller asks for the next transfer |
| tx_count | input | CNT_W | Bytes held in the transmit queue |
| tx_head | input | 8·LANES | First LANES queue bytes, byte k at bits 8k+7:8k |
| tx_pop | output | 1 | Pop pulse to the transmit queue |
| tx_pop_cnt | output | PW | Number of bytes popped |
| lane_go | output | 1 | Launch pulse to the lane serializers |
| lane_tx | output | 8·LANES | Byte for each lane, lane j at bits 8j+7:8j |
| lane_ack | input | 1 | Lanes finished the transfer in flight |
| lane_rx | input | 8·LANES | Byte received on each lane |
| rx_full | input | 1 | Receive queue cannot accept bytes |
| rx_push | output | 1 | Push pulse to the receive queue |
| rx_push_cnt | output | PW | Number of bytes pushed |
| rx_data | output | 8·LANES | Bytes to push, byte k at bits 8k+7:8k |
| ev_tx_underflow | output | 1 | Transmit underflow event |
| ev_rx_overflow | output | 1 | Receive overflow event |

## Verification
The hardest state to reach is a striped phase in which the transmit queue holds an odd byte count while the receive queue reports full as a completion arrives. Reaching it needs a recognised command, the exact number of address and dummy transfers, and completion latencies that move about. The stimulus sends each command class with its full address run and leaves one data byte over so the wait is observed. It adds the last byte only later, toggles `rx_full` at random during whole commands, and varies the lane response delay from one to three cycles. A behavioural model built from queues and integers predicts every output port on every cycle.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [1:0] {
    SN_WATCH  = 2'd0,
    SN_COUNT  = 2'd1,
    SN_PLAIN  = 2'd2,
    SN_STRIPE = 2'd3
  } snoop_mode_t;

  localparam int SKIP_W = 3;

  // Number of broadcast transfers after the command byte; 0 means unknown command.
  function automatic logic [SKIP_W-1:0] skip_for_opcode(input logic [7:0] op);
    logic [SKIP_W-1:0] r;
    case (op)
      8'h02, 8'h03, 8'h32, 8'hA2: r = SKIP_W'(3);
      8'h0B, 8'h3B, 8'h6B, 8'hBB: r = SKIP_W'(4);
      8'hEB:                      r = SKIP_W'(6);
      default:                    r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_out = sync_q;
endmodule

// File: rtl/bit_lane_transpose.sv
module bit_lane_transpose #(
  parameter int LANES   = 2,
  parameter bit INVERSE = 1'b0
) (
  input  logic [LANES*8-1:0] din,
  output logic [LANES*8-1:0] dout
);
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    for (genvar b = 0; b < 8; b++) begin : g_bit
      localparam int FLAT = b * LANES + j;
      if (!INVERSE) begin : g_fwd
        assign dout[j*8+b] = din[FLAT];
      end else begin : g_inv
        assign dout[FLAT] = din[j*8+b];
      end
    end
  end
endmodule

// File: rtl/snoop_tracker.sv
module snoop_tracker
  import snoop_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_active,
  input  logic       step,
  input  logic [7:0] opcode,
  output logic       striping
);
  snoop_mode_t       mode_q, mode_d;
  logic [SKIP_W-1:0] skip_q, skip_d;
  logic [SKIP_W-1:0] decoded;
  logic              upd_en;

  assign decoded = skip_for_opcode(opcode);
  assign upd_en  = !cs_active || step;

  always_comb begin
    mode_d = mode_q;
    skip_d = skip_q;
    if (!cs_active) begin
      mode_d = SN_WATCH;
      skip_d = '0;
    end else if (step) begin
      case (mode_q)
        SN_WATCH: begin
          if (decoded != '0) begin
            mode_d = SN_COUNT;
            skip_d = decoded;
          end else begin
            mode_d = SN_PLAIN;
          end
        end
        SN_COUNT: begin
          skip_d = skip_q - SKIP_W'(1);
          if (skip_q == SKIP_W'(1)) mode_d = SN_STRIPE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SN_WATCH;
      skip_q <= '0;
    end else if (upd_en) begin
      mode_q <= mode_d;
      skip_q <= skip_d;
    end
  end

  assign striping = (mode_q == SN_STRIPE);
endmodule

// File: rtl/cmd_snoop_striper.sv
module cmd_snoop_striper #(
  parameter int LANES      = 2,
  parameter int FIFO_DEPTH = 256,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int PW        = $clog2(LANES + 1),
  localparam int DW        = LANES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_active,
  input  logic             linear_mode,
  input  logic             xfer_req,
  input  logic [CNT_W-1:0] tx_count,
  input  logic [DW-1:0]    tx_head,
  output logic             tx_pop,
  output logic [PW-1:0]    tx_pop_cnt,
  output logic             lane_go,
  output logic [DW-1:0]    lane_tx,
  input  logic             lane_ack,
  input  logic [DW-1:0]    lane_rx,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [PW-1:0]    rx_push_cnt,
  output logic [DW-1:0]    rx_data,
  output logic             ev_tx_underflow,
  output logic             ev_rx_overflow
);
  logic          rst_n_s;
  logic          striping;
  logic          busy_q, busy_d;
  logic          str_q;
  logic [7:0]    op_q;
  logic [PW-1:0] need;
  logic          asking;
  logic          launch;
  logic          done;
  logic [DW-1:0] tx_striped;
  logic [DW-1:0] rx_unstriped;

  rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  snoop_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cs_active (cs_active),
    .step      (done),
    .opcode    (op_q),
    .striping  (striping)
  );

  bit_lane_transpose #(.LANES(LANES), .INVERSE(1'b0)) u_fwd (
    .din  (tx_head),
    .dout (tx_striped)
  );

  bit_lane_transpose #(.LANES(LANES), .INVERSE(1'b1)) u_inv (
    .din  (lane_rx),
    .dout (rx_unstriped)
  );

  assign need   = striping ? PW'(LANES) : PW'(1);
  assign asking = !busy_q && cs_active && xfer_req;
  assign launch = asking && (tx_count >= CNT_W'(need));
  assign done   = busy_q && lane_ack;

  // Launch side
  assign tx_pop          = launch;
  assign tx_pop_cnt      = need;
  assign lane_go         = launch;
  assign lane_tx         = striping ? tx_striped : {LANES{tx_head[7:0]}};
  assign ev_tx_underflow = asking && (tx_count == '0) && !linear_mode;

  // Completion side
  assign rx_push        = done && !rx_full;
  assign ev_rx_overflow = done && rx_full;
  assign rx_push_cnt    = str_q ? PW'(LANES) : PW'(1);
  assign rx_data        = str_q ? rx_unstriped : DW'(lane_rx[7:0]);

  always_comb begin
    busy_d = busy_q;
    if (launch)    busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      str_q <= 1'b0;
      op_q  <= '0;
    end else if (launch) begin
      str_q <= striping;
      op_q  <= tx_head[7:0];
    end
  end
endmodule

// File: rtl/snoop_striper_chk.sv
module snoop_striper_chk #(
  parameter int LANES = 2,
  parameter int CNT_W = 9,
  parameter int PW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_active,
  input logic             linear_mode,
  input logic [CNT_W-1:0] tx_count,
  input logic             tx_pop,
  input logic [PW-1:0]    tx_pop_cnt,
  input logic             lane_go,
  input logic [LANES*8-1:0] lane_tx,
  input logic             rx_full,
  input logic             rx_push,
  input logic             ev_tx_underflow,
  input logic             ev_rx_overflow
);
  assert_no_go_idle_cs_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_active |-> !lane_go && !tx_pop);

  assert_broadcast_same_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && tx_pop_cnt == PW'(1)) |-> (lane_tx == {LANES{lane_tx[7:0]}}));

  assert_no_push_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rx_push);

  assert_ovf_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_overflow |-> !rx_push);

  assert_underflow_cond_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_underflow |-> (!linear_mode && tx_count == '0 && !tx_pop));

  assert_pop_avail_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> (tx_count >= CNT_W'(tx_pop_cnt)));

  assert_one_flight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lane_go |=> !lane_go);
endmodule

bind cmd_snoop_striper snoop_striper_chk #(
  .LANES (LANES),
  .CNT_W (CNT_W),
  .PW    (PW)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cs_active       (cs_active),
  .linear_mode     (linear_mode),
  .tx_count        (tx_count),
  .tx_pop          (tx_pop),
  .tx_pop_cnt      (tx_pop_cnt),
  .lane_go         (lane_go),
  .lane_tx         (lane_tx),
  .rx_full         (rx_full),
  .rx_push         (rx_push),
  .ev_tx_underflow (ev_tx_underflow),
  .ev_rx_overflow  (ev_rx_overflow)
);

// File: tb/tb_cmd_snoop_striper.sv
module tb_cmd_snoop_striper;
  localparam int L      = 2;
  localparam int DEPTH  = 256;
  localparam int CW     = $clog2(DEPTH + 1);
  localparam int PWB    = $clog2(L + 1);
  localparam int DWB    = L * 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cs_active, linear_mode, xfer_req, lane_ack, rx_full;
  logic [CW-1:0]  tx_count;
  logic [DWB-1:0] tx_head, lane_rx, lane_tx, rx_data;
  logic           tx_pop, lane_go, rx_push, ev_tx_underflow, ev_rx_overflow;
  logic [PWB-1:0] tx_pop_cnt, rx_push_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_snoop_striper #(.LANES(L), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cs_active(cs_active), .linear_mode(linear_mode),
    .xfer_req(xfer_req), .tx_count(tx_count), .tx_head(tx_head),
    .tx_pop(tx_pop), .tx_pop_cnt(tx_pop_cnt), .lane_go(lane_go), .lane_tx(lane_tx),
    .lane_ack(lane_ack), .lane_rx(lane_rx), .rx_full(rx_full), .rx_push(rx_push),
    .rx_push_cnt(rx_push_cnt), .rx_data(rx_data),
    .ev_tx_underflow(ev_tx_underflow), .ev_rx_overflow(ev_rx_overflow)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done_flag = 0;

  logic [7:0] txq[$];
  // model: 0 watch, 1 counting, 2 plain, 3 striped
  int m_mode, m_cnt;
  bit m_busy, m_str;
  logic [7:0] m_op;
  // lane responder
  bit r_pend;
  int r_dly;
  logic [DWB-1:0] r_data;
  int full_pat;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  function automatic logic [DWB-1:0] fwd(input logic [DWB-1:0] x);
    logic [DWB-1:0] r;
    for (int j = 0; j < L; j++)
      for (int b = 0; b < 8; b++) r[j*8+b] = x[b*L+j];
    return r;
  endfunction

  function automatic logic [DWB-1:0] inv(input logic [DWB-1:0] x);
    logic [DWB-1:0] r;
    for (int j = 0; j < L; j++)
      for (int b = 0; b < 8; b++) r[b*L+j] = x[j*8+b];
    return r;
  endfunction

  function automatic int skip_of(input logic [7:0] op);
    case (op)
      8'h02, 8'h03, 8'h32, 8'hA2: return 3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: return 4;
      8'hEB: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic one_cycle();
    int need, cnt;
    bit ask, e_go, e_push, e_ovf, e_unf, done_e;
    logic [DWB-1:0] e_tx, e_rx;
    string lbl;
    cnt = txq.size();
    tx_count = CW'(cnt);
    tx_head = '0;
    for (int k = 0; k < L; k++) if (k < cnt) tx_head[k*8 +: 8] = txq[k];
    lane_ack = r_pend && (r_dly == 0);
    lane_rx  = r_data;
    rx_full  = (full_pat != 0) ? (($urandom % 3) == 0) : 1'b0;
    #1;
    need   = (m_mode == 3) ? L : 1;
    ask    = !m_busy && cs_active && xfer_req;
    e_go   = ask && (cnt >= need);
    e_unf  = ask && (cnt == 0) && !linear_mode;
    done_e = m_busy && lane_ack;
    e_push = done_e && !rx_full;
    e_ovf  = done_e && rx_full;
    if (m_mode == 3) e_tx = fwd(tx_head);
    else e_tx = {L{tx_head[7:0]}};
    e_rx = m_str ? inv(lane_rx) : DWB'(lane_rx[7:0]);

    chk(lane_go == e_go, cs_active ? "R10" : "R1", 32'(lane_go), 32'(e_go));
    chk(tx_pop == e_go, (ask && cnt > 0 && cnt < need) ? "R9" : "R10", 32'(tx_pop), 32'(e_go));
    chk(ev_tx_underflow == e_unf, (ask && cnt > 0) ? "R9" : "R8", 32'(ev_tx_underflow), 32'(e_unf));
    chk(ev_rx_overflow == e_ovf, "R7", 32'(ev_rx_overflow), 32'(e_ovf));
    chk(rx_push == e_push, "R7", 32'(rx_push), 32'(e_push));
    if (e_go) begin
      case (m_mode)
        0: lbl = "R11";
        1: lbl = "R2";
        2: lbl = "R3";
        default: lbl = "R5";
      endcase
      chk(tx_pop_cnt == PWB'(need), (need == 1) ? "R4" : "R5", 32'(tx_pop_cnt), 32'(need));
      chk(lane_tx == e_tx, lbl, 32'(lane_tx), 32'(e_tx));
    end
    if (e_push) begin
      chk(rx_push_cnt == PWB'(m_str ? L : 1), m_str ? "R6" : "R4", 32'(rx_push_cnt), 32'(m_str ? L : 1));
      chk(rx_data == e_rx, m_str ? "R6" : "R4", 32'(rx_data), 32'(e_rx));
    end

    @(posedge clk);
    cycles++;
    // model update with pre-edge values
    if (e_go) begin
      for (int k = 0; k < need; k++) void'(txq.pop_front());
      m_busy = 1; m_str = (m_mode == 3); m_op = tx_head[7:0];
    end else if (done_e) m_busy = 0;
    if (!cs_active) begin
      m_mode = 0; m_cnt = 0;
    end else if (done_e) begin
      if (m_mode == 0) begin
        m_cnt = skip_of(m_op);
        m_mode = (m_cnt != 0) ? 1 : 2;
      end else if (m_mode == 1) begin
        m_cnt--;
        if (m_cnt == 0) m_mode = 3;
      end
    end
    // responder reacts to the actual launch
    if (lane_ack) r_pend = 0;
    else if (r_pend) r_dly--;
    if (lane_go) begin
      r_pend = 1;
      r_dly = cycles % 3;
      r_data = lane_tx ^ {L{8'h5A}} ^ DWB'(cycles);
    end
    @(negedge clk);
  endtask

  task automatic push_bytes(input logic [7:0] op, input int extra);
    txq.push_back(op);
    for (int k = 0; k < extra; k++) txq.push_back(8'($urandom));
  endtask

  task automatic run_until_drained(input int tail);
    int guard = 0;
    while ((txq.size() != 0 || m_busy) && guard < 400) begin
      one_cycle();
      guard++;
    end
    for (int k = 0; k < tail; k++) one_cycle();
  endtask

  task automatic end_cmd();
    xfer_req = 0;
    one_cycle();
    cs_active = 0;
    one_cycle();
    one_cycle();
  endtask

  initial begin
    rst_n = 0; cs_active = 0; linear_mode = 0; xfer_req = 0; lane_ack = 0; rx_full = 0;
    tx_count = '0; tx_head = '0; lane_rx = '0;
    m_mode = 0; m_cnt = 0; m_busy = 0; m_str = 0; m_op = '0;
    r_pend = 0; r_dly = 0; r_data = '0; full_pat = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    chk(lane_go == 0 && tx_pop == 0, "R1", 32'({lane_go, tx_pop}), 0);
    chk(rx_push == 0 && ev_tx_underflow == 0 && ev_rx_overflow == 0, "R1",
        32'({rx_push, ev_tx_underflow, ev_rx_overflow}), 0);
    @(negedge clk);

    // R1: request while chip select idle does nothing
    push_bytes(8'h03, 3);
    xfer_req = 1;
    repeat (4) one_cycle();
    // R2 three-skip command, then striped data, then underflow (R8)
    cs_active = 1;
    for (int k = 0; k < 6; k++) txq.push_back(8'($urandom));
    run_until_drained(3);
    end_cmd();

    // R2 six-skip, odd data count -> wait (R9), random rx_full (R7)
    full_pat = 1;
    push_bytes(8'hEB, 6 + 5);
    cs_active = 1; xfer_req = 1;
    while (txq.size() > 1 || m_busy) one_cycle();
    repeat (5) one_cycle();
    txq.push_back(8'hC3);
    run_until_drained(1);
    end_cmd();
    full_pat = 0;

    // R3 unknown command stays broadcast
    push_bytes(8'h9F, 8);
    cs_active = 1; xfer_req = 1;
    run_until_drained(2);
    end_cmd();

    // R2 four-skip command in linear mode: no underflow (R8)
    linear_mode = 1;
    push_bytes(8'h0B, 4 + 6);
    cs_active = 1; xfer_req = 1;
    run_until_drained(4);
    end_cmd();
    linear_mode = 0;

    // R11 release mid-stripe, then a new command decodes again
    push_bytes(8'hA2, 3 + 2);
    cs_active = 1; xfer_req = 1;
    run_until_drained(0);
    end_cmd();
    full_pat = 1;
    push_bytes(8'h6B, 4 + 8);
    cs_active = 1; xfer_req = 1;
    run_until_drained(2);
    end_cmd();
    full_pat = 0;

    // R10 stray acknowledge with nothing in flight
    r_pend = 1; r_dly = 0;
    one_cycle();
    one_cycle();

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired: actual %0d expected %0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule